// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a processor core whose register view changes with the operating mode. The core gives it the current 5-bit mode code. Every access to a logical register index 0 to 14 is steered to a physical storage cell chosen by that mode. A fast-interrupt mode has private copies of the upper seven registers. Four other exception modes each have private stack-pointer and link registers (indices 13 and 14). The two ordinary modes share one common set.

Beside the general registers, the block stores one saved-status word for each exception mode. It reports through a flag when the current mode has no such word. Logical index 15 is not stored here: reads of it return a program-counter value supplied from outside. A user-view override lets privileged code reach the shared registers directly, for register transfers.

Two read ports are combinational. The single general write port and the saved-status write port both commit on the rising clock edge.

Top module: `mode_bank_rf`

## Requirements
- R1: In User mode (code 10000) and System mode (code 11111), indices 0 to 14 all address one shared set of registers, so a value written in either mode is read back in the other.
- R2: In FIQ mode (code 10001), indices 8 to 14 address seven private registers. Indices 0 to 7 address the shared set.
- R3: In IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011) modes, indices 13 and 14 address a pair of registers private to that mode. Indices 0 to 12 address the shared set.
- R4: Each of the five exception modes (FIQ, IRQ, Supervisor, Abort, Undefined) has its own saved-status word. It is read combinationally on `psr_rd_data` and written on the clock edge when `psr_wr_en` is high. In these modes `no_psr` is 0.
- R5: In User and System modes, `no_psr` is 1, `psr_rd_data` reads 0, and `psr_wr_en` changes no saved-status word.
- R6: A read of index 15 on either port returns `pc_in`. A write to index 15 changes no stored register.
- R7: Writes take effect at the rising clock edge. A read in the same cycle as a write to the same register returns the old value, and the next cycle returns the new one.
- R8: While `usr_map` is 1, indices 0 to 14 address the shared User set whatever the mode. Saved-status access still follows the mode.
- R9: An active-low `rst_n` clears every general register and every saved-status word to zero.
- R10: Any mode code not listed in R1 to R4 maps the general registers as User mode and has no saved-status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 5 | Current operating mode code |
| usr_map | input | 1 | Force the User register mapping for indices 0 to 14 |
| pc_in | input | 32 | Value returned for index 15 |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write logical index |
| wr_data | input | 32 | General write data |
| psr_wr_en | input | 1 | Saved-status write enable |
| psr_wr_data | input | 32 | Saved-status write data |
| psr_rd_data | output | 32 | Saved-status word of the current mode |
| no_psr | output | 1 | High when the current mode has no saved-status word |

## Verification
Read data, saved-status data and the `no_psr` flag are due in the same cycle their inputs are applied. Written values are due from the first cycle after the rising edge that commits them. The bench drives every input just after a falling edge and compares the outputs against its behavioural model 1 ns later. It then applies the cycle's writes to the model, which stands for the edge that follows. A read of a register being written therefore expects the old value in that cycle and the new one in the next cycle, as R7 demands.

// File: rtl/mode_bank_rf.sv
`timescale 1ns/1ps
module mode_bank_rf #(
  parameter int DW    = 32,
  parameter int NPHYS = 30,
  parameter int NSPSR = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode,
  input  logic          usr_map,
  input  logic [DW-1:0] pc_in,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          psr_wr_en,
  input  logic [DW-1:0] psr_wr_data,
  output logic [DW-1:0] psr_rd_data,
  output logic          no_psr
);
  localparam int PW = $clog2(NPHYS);
  localparam int SW = $clog2(NSPSR);

  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;

  // Shared cells 0..14, FIQ 15..21, IRQ 22..23, SVC 24..25, ABT 26..27, UND 28..29
  function automatic logic [PW-1:0] phys_of(input logic [3:0] idx, input logic [4:0] md,
                                            input logic um);
    logic [PW-1:0] p;
    p = PW'(idx);
    if (!um) begin
      case (md)
        M_FIQ: if (idx >= 4'd8)  p = PW'(idx) + PW'(7);
        M_IRQ: if (idx >= 4'd13) p = PW'(idx) + PW'(9);
        M_SVC: if (idx >= 4'd13) p = PW'(idx) + PW'(11);
        M_ABT: if (idx >= 4'd13) p = PW'(idx) + PW'(13);
        M_UND: if (idx >= 4'd13) p = PW'(idx) + PW'(15);
        default: ;
      endcase
    end
    return p;
  endfunction

  logic [DW-1:0] gpr  [NPHYS];
  logic [DW-1:0] spsr [NSPSR];
  logic [SW-1:0] slot;
  logic          has_psr;
  logic [PW-1:0] wr_p, ra_p, rb_p;

  always_comb begin
    has_psr = 1'b1;
    slot    = '0;
    case (mode)
      M_FIQ: slot = SW'(0);
      M_IRQ: slot = SW'(1);
      M_SVC: slot = SW'(2);
      M_ABT: slot = SW'(3);
      M_UND: slot = SW'(4);
      default: has_psr = 1'b0;
    endcase
  end

  assign wr_p = phys_of(wr_idx,   mode, usr_map);
  assign ra_p = phys_of(rd_a_idx, mode, usr_map);
  assign rb_p = phys_of(rd_b_idx, mode, usr_map);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) gpr[i] <= '0;
      for (int j = 0; j < NSPSR; j++) spsr[j] <= '0;
    end else begin
      if (wr_en && wr_idx != 4'hF) gpr[wr_p] <= wr_data;
      if (psr_wr_en && has_psr)    spsr[slot] <= psr_wr_data;
    end
  end

  assign rd_a_data   = (rd_a_idx == 4'hF) ? pc_in : gpr[ra_p];
  assign rd_b_data   = (rd_b_idx == 4'hF) ? pc_in : gpr[rb_p];
  assign psr_rd_data = has_psr ? spsr[slot] : '0;
  assign no_psr      = !has_psr;

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R5
  psr_absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_psr |-> psr_rd_data == '0);

  // R6
  pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == 4'hF |-> rd_b_data == pc_in);

  // R7
  gpr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en) && $past(wr_idx) != 4'hF && rd_a_idx == $past(wr_idx)
    && mode == $past(mode) && usr_map == $past(usr_map) |-> rd_a_data == $past(wr_data));

  // R4
  psr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(psr_wr_en) && !$past(no_psr) && mode == $past(mode)
    |-> psr_rd_data == $past(psr_wr_data));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && rd_a_idx != 4'hF |-> rd_a_data == '0);
endmodule

// File: tb/test_mode_bank_rf.sv
`timescale 1ns/1ps
module test_mode_bank_rf;
  logic clk = 0, rst_n = 0, usr_map = 0, wr_en = 0, psr_wr_en = 0;
  logic [4:0] mode = 5'b10000;
  logic [31:0] pc_in = 32'h0000_1000, wr_data = 0, psr_wr_data = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, psr_rd_data;
  logic no_psr;
  int n_chk = 0, n_fail = 0;
  string force_tag = "";

  always #2.5 clk = ~clk;

  mode_bank_rf i_mode_bank_rf (.clk, .rst_n, .mode, .usr_map, .pc_in, .rd_a_idx, .rd_a_data,
    .rd_b_idx, .rd_b_data, .wr_en, .wr_idx, .wr_data, .psr_wr_en, .psr_wr_data,
    .psr_rd_data, .no_psr);

  // Behavioural model: shared set, FIQ private 8..14, four pairs 13..14, five status words
  logic [31:0] m_usr [0:14];
  logic [31:0] m_fiq [8:14];
  logic [31:0] m_pair [0:3][13:14];
  logic [31:0] m_psr [0:4];

  function automatic int pair_of(input logic [4:0] md);
    if (md == 5'b10010) return 0;
    if (md == 5'b10011) return 1;
    if (md == 5'b10111) return 2;
    if (md == 5'b11011) return 3;
    return -1;
  endfunction

  function automatic int psr_of(input logic [4:0] md);
    if (md == 5'b10001) return 4;
    return pair_of(md);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] md, input logic um, input logic [3:0] ix);
    if (ix == 15) return pc_in;
    if (!um && md == 5'b10001 && ix >= 8) return m_fiq[ix];
    if (!um && pair_of(md) >= 0 && ix >= 13) return m_pair[pair_of(md)][ix];
    return m_usr[ix];
  endfunction

  task automatic m_write(input logic [4:0] md, input logic um, input logic [3:0] ix, input logic [31:0] d);
    if (ix == 15) return;
    if (!um && md == 5'b10001 && ix >= 8) m_fiq[ix] = d;
    else if (!um && pair_of(md) >= 0 && ix >= 13) m_pair[pair_of(md)][ix] = d;
    else m_usr[ix] = d;
  endtask

  function automatic string tag_of(input logic [4:0] md, input logic um, input logic [3:0] ix);
    if (force_tag != "") return force_tag;
    if (ix == 15) return "R6";
    if (um) return "R8";
    if (md == 5'b10001) return "R2";
    if (pair_of(md) >= 0) return "R3";
    if (md == 5'b10000 || md == 5'b11111) return "R1";
    return "R10";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string pt;
    int s;
    s = psr_of(mode);
    pt = (force_tag != "") ? force_tag : ((s >= 0) ? "R4" : ((mode == 5'b10000 || mode == 5'b11111) ? "R5" : "R10"));
    check(tag_of(mode, usr_map, rd_a_idx), "rd_a", rd_a_data, m_read(mode, usr_map, rd_a_idx));
    check(tag_of(mode, usr_map, rd_b_idx), "rd_b", rd_b_data, m_read(mode, usr_map, rd_b_idx));
    check(pt, "psr_rd", psr_rd_data, (s >= 0) ? m_psr[s] : 32'h0);
    check(pt, "no_psr", {31'h0, no_psr}, {31'h0, s < 0});
  endtask

  task automatic step(input logic [4:0] md, input logic um, input logic [3:0] ra, input logic [3:0] rb,
                      input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input logic pwe, input logic [31:0] pwd);
    @(negedge clk);
    mode = md; usr_map = um; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd; psr_wr_en = pwe; psr_wr_data = pwd;
    pc_in = $urandom;
    #1;
    compare_all();
    if (we) m_write(md, um, wi, wd);
    if (pwe && psr_of(md) >= 0) m_psr[psr_of(md)] = pwd;
  endtask

  localparam logic [4:0] MODES [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                                       5'b11011, 5'b11111, 5'b10110, 5'b00000};

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) m_usr[i] = 0;
    for (int i = 8; i < 15; i++) m_fiq[i] = 0;
    for (int p = 0; p < 4; p++) begin m_pair[p][13] = 0; m_pair[p][14] = 0; end
    for (int i = 0; i < 5; i++) m_psr[i] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: all storage reads zero while and after reset
    force_tag = "R9";
    for (int k = 0; k < 7; k++) begin
      mode = MODES[k]; rd_a_idx = 4'd14; rd_b_idx = 4'd9; #1;
      compare_all();
      @(negedge clk);
    end
    rst_n = 1;
    step(5'b10001, 0, 4'd13, 4'd8, 0, 0, 0, 0, 0);
    force_tag = "";
    // R1: write in User, read back in System
    step(5'b10000, 0, 4'd3, 4'd3, 1, 4'd3, 32'hAAAA_0003, 0, 0);
    step(5'b11111, 0, 4'd3, 4'd13, 1, 4'd13, 32'h5555_000D, 0, 0);
    // R2 / R3: banked copies stay distinct
    step(5'b10001, 0, 4'd13, 4'd3, 1, 4'd13, 32'hF1F1_000D, 0, 0);
    step(5'b10010, 0, 4'd13, 4'd12, 1, 4'd13, 32'h1212_000D, 0, 0);
    step(5'b10011, 0, 4'd13, 4'd14, 0, 0, 0, 0, 0);
    step(5'b10000, 0, 4'd13, 4'd3, 0, 0, 0, 0, 0);
    // R7: same-cycle read returns old value, next cycle the new one
    force_tag = "R7";
    step(5'b10111, 0, 4'd14, 4'd14, 1, 4'd14, 32'hABAB_0E0E, 0, 0);
    step(5'b10111, 0, 4'd14, 4'd14, 0, 0, 0, 0, 0);
    // R6: write to index 15 is dropped
    force_tag = "R6";
    step(5'b10000, 0, 4'd15, 4'd0, 1, 4'd15, 32'hDEAD_BEEF, 0, 0);
    step(5'b10000, 0, 4'd15, 4'd14, 0, 0, 0, 0, 0);
    // R4 / R5: status words per mode; absent in User, System and unknown codes
    force_tag = "R4";
    step(5'b11011, 0, 0, 0, 0, 0, 0, 1, 32'h600D_0011);
    step(5'b11011, 0, 0, 0, 0, 0, 0, 0, 0);
    step(5'b10001, 0, 0, 0, 0, 0, 0, 0, 0);
    force_tag = "R5";
    step(5'b10000, 0, 0, 0, 0, 0, 0, 1, 32'hBAD0_0001);
    step(5'b11111, 0, 0, 0, 0, 0, 0, 1, 32'hBAD0_0002);
    force_tag = "R10";
    step(5'b10110, 0, 4'd13, 4'd9, 1, 4'd9, 32'h0BAD_0009, 1, 32'hBAD0_0003);
    step(5'b10000, 0, 4'd9, 4'd13, 0, 0, 0, 0, 0);
    // R8: user view override in privileged modes
    force_tag = "R8";
    step(5'b10001, 1, 4'd10, 4'd14, 1, 4'd10, 32'h0808_0A0A, 0, 0);
    step(5'b10000, 0, 4'd10, 4'd10, 0, 0, 0, 0, 0);
    step(5'b10011, 1, 4'd14, 4'd13, 0, 0, 0, 1, 32'h5C5C_0001);
    step(5'b10011, 0, 4'd14, 4'd13, 0, 0, 0, 0, 0);
    force_tag = "";
    // Mixed traffic across all modes
    for (int c = 0; c < 3000; c++) begin
      step(MODES[$urandom_range(0, 8)], ($urandom_range(0, 7) == 0),
           4'($urandom), 4'($urandom), $urandom_range(0, 1) == 1, 4'($urandom), $urandom,
           $urandom_range(0, 3) == 0, $urandom);
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule